// File: doc/BRIEF.md
# Configurable Word Shifter and Rotator

A purely combinational datapath element that moves the bits of a data word left or right by a
programmable distance. A three-bit operation code picks one of six treatments of the vacated
positions: filled with zero, filled with a copy of an edge bit of the original word, or refilled
with the bits that fall off the other end (rotation). Two spare operation codes pass the word
through untouched.

The shift distance ranges from zero to one less than the word width. Internally, every operation
is reduced to a left-moving logarithmic barrel. Right-moving operations are handled by mirroring
the word before the barrel and mirroring it again after. The block holds no state, so a result
follows its inputs within the same clock cycle and can sit between two register stages.

Top module: `wsh_word_shifter`

## Requirements
- R1: Operation code 3'b000 (logical left) gives the word moved left by the amount, with zeros in the vacated low positions; for example, 8'h95 by 2 gives 8'h54.
- R2: Operation code 3'b001 (logical right) gives the word moved right by the amount, with zeros in the vacated high positions; for example, 8'h95 by 3 gives 8'h12.
- R3: Operation code 3'b010 (arithmetic left) gives the word moved left by the amount, with every vacated low position holding the original bit 0; for example, 8'h95 by 3 gives 8'hAF.
- R4: Operation code 3'b011 (arithmetic right) gives the word moved right by the amount, with every vacated high position holding the original most significant bit; for example, 8'h95 by 2 gives 8'hE5.
- R5: Operation code 3'b100 (rotate left) gives result bit i equal to input bit (i - amount) mod 8; for example, 8'h95 by 3 gives 8'hAC.
- R6: Operation code 3'b101 (rotate right) gives result bit i equal to input bit (i + amount) mod 8; for example, 8'h95 by 5 gives 8'hAC.
- R7: Operation codes 3'b110 and 3'b111 return the input word unchanged, whatever the amount.
- R8: An amount of 0 returns the input word unchanged for every operation code.
- R9: The result depends only on the present inputs, with no clock and no storage; a change on any input shows in the result within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 8 | Word to be shifted or rotated |
| op_i | input | 3 | Operation code (see R1 to R7) |
| amt_i | input | 3 | Shift distance, 0 to 7 |
| result_o | output | 8 | Shifted or rotated word |

## Verification
Whenever the inputs are known, the assertions check several invariants: a zero distance and the spare codes return the word unchanged, rotations keep the number of set bits, logical shifts leave zeros in the vacated positions, and arithmetic shifts leave copies of the edge bit there. Only the bench's scenarios can show that each bit lands in its correct position. The bench covers every operation at every distance over several data patterns, the worked examples, and that a changed input reaches the result within the same cycle.

// File: rtl/wsh_pkg.sv
package wsh_pkg;
    localparam int WORD_W = 8;
    localparam int AMT_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        OP_LSL  = 3'b000,
        OP_LSR  = 3'b001,
        OP_ASL  = 3'b010,
        OP_ASR  = 3'b011,
        OP_ROL  = 3'b100,
        OP_ROR  = 3'b101,
        OP_PASA = 3'b110,
        OP_PASB = 3'b111
    } wsh_op_e;

    // Control bundle steering the shared left barrel
    typedef struct packed {
        logic mirror;   // operate on the bit-reversed word
        logic rotate;   // refill from bits leaving the top
        logic fill;     // fill bit when not rotating
        logic pass;     // bypass the barrel
    } wsh_ctl_t;
endpackage

// File: rtl/wsh_decode.sv
module wsh_decode
    import wsh_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic       msb_i,
    input  logic       lsb_i,
    output wsh_ctl_t   ctl_o
);
    always_comb begin
        ctl_o = '{mirror: 1'b0, rotate: 1'b0, fill: 1'b0, pass: 1'b0};
        unique case (wsh_op_e'(op_i))
            OP_LSL: ;
            OP_LSR: ctl_o.mirror = 1'b1;
            OP_ASL: ctl_o.fill   = lsb_i;
            OP_ASR: begin
                ctl_o.mirror = 1'b1;
                ctl_o.fill   = msb_i;
            end
            OP_ROL: ctl_o.rotate = 1'b1;
            OP_ROR: begin
                ctl_o.mirror = 1'b1;
                ctl_o.rotate = 1'b1;
            end
            default: ctl_o.pass = 1'b1;
        endcase
    end
endmodule

// File: rtl/wsh_bitrev.sv
module wsh_bitrev #(
    parameter int W = 8
) (
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] rev;
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = d_i[W-1-i];
    end
    assign q_o = en_i ? rev : d_i;
endmodule

// File: rtl/wsh_left_barrel.sv
module wsh_left_barrel #(
    parameter int W = 8,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  d_i,
    input  logic [AW-1:0] amt_i,
    input  logic          rotate_i,
    input  logic          fill_i,
    output logic [W-1:0]  q_o
);
    logic [W-1:0] stage [AW+1];
    assign stage[0] = d_i;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [S-1:0] refill;
        assign refill = rotate_i ? stage[k][W-1 -: S] : {S{fill_i}};
        assign stage[k+1] = amt_i[k] ? {stage[k][W-1-S:0], refill} : stage[k];
    end

    assign q_o = stage[AW];
endmodule

// File: rtl/wsh_word_shifter.sv
module wsh_word_shifter
    import wsh_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    input  logic [2:0]        op_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [WORD_W-1:0] result_o
);
    wsh_ctl_t          ctl;
    logic [WORD_W-1:0] pre, shifted, post;

    wsh_decode u_dec (
        .op_i  (op_i),
        .msb_i (data_i[WORD_W-1]),
        .lsb_i (data_i[0]),
        .ctl_o (ctl)
    );

    wsh_bitrev #(.W(WORD_W)) u_rev_in (
        .en_i (ctl.mirror), .d_i (data_i), .q_o (pre)
    );

    wsh_left_barrel #(.W(WORD_W)) u_barrel (
        .d_i      (pre),
        .amt_i    (amt_i),
        .rotate_i (ctl.rotate),
        .fill_i   (ctl.fill),
        .q_o      (shifted)
    );

    wsh_bitrev #(.W(WORD_W)) u_rev_out (
        .en_i (ctl.mirror), .d_i (shifted), .q_o (post)
    );

    assign result_o = ctl.pass ? data_i : post;

    // Invariants checked whenever the inputs are known
    always_comb begin
        if (!$isunknown({data_i, op_i, amt_i})) begin
            if (amt_i == '0)
                p_zero_amt_identity_r8: assert (result_o == data_i);
            if (op_i[2:1] == 2'b11)
                p_spare_code_pass_r7: assert (result_o == data_i);
            if (op_i == OP_ROL)
                p_rol_keeps_ones_r5: assert ($countones(result_o) == $countones(data_i));
            if (op_i == OP_ROR)
                p_ror_keeps_ones_r6: assert ($countones(result_o) == $countones(data_i));
            if (op_i == OP_LSL)
                p_lsl_low_zero_r1: assert ((result_o & ~({WORD_W{1'b1}} << amt_i)) == '0);
            if (op_i == OP_LSR)
                p_lsr_high_zero_r2: assert ((result_o & ~({WORD_W{1'b1}} >> amt_i)) == '0);
            if (op_i == OP_ASL)
                p_asl_low_copy_r3: assert ((result_o & ~({WORD_W{1'b1}} << amt_i))
                                           == ({WORD_W{data_i[0]}} & ~({WORD_W{1'b1}} << amt_i)));
            if (op_i == OP_ASR)
                p_asr_high_copy_r4: assert ((result_o & ~({WORD_W{1'b1}} >> amt_i))
                                            == ({WORD_W{data_i[WORD_W-1]}} & ~({WORD_W{1'b1}} >> amt_i)));
        end
    end
endmodule

// File: tb/tb_wsh_word_shifter.sv
module tb_wsh_word_shifter;
    localparam int W = 8;
    localparam int NV = 10;
    // {op, amt, data, expected}
    localparam logic [21:0] VEC [NV] = '{
        {3'b000, 3'd2, 8'h95, 8'h54},
        {3'b001, 3'd3, 8'h95, 8'h12},
        {3'b010, 3'd3, 8'h95, 8'hAF},
        {3'b011, 3'd2, 8'h95, 8'hE5},
        {3'b100, 3'd3, 8'h95, 8'hAC},
        {3'b101, 3'd5, 8'h95, 8'hAC},
        {3'b110, 3'd4, 8'h95, 8'h95},
        {3'b111, 3'd7, 8'h3C, 8'h3C},
        {3'b011, 3'd7, 8'h80, 8'hFF},
        {3'b010, 3'd7, 8'h01, 8'hFF}
    };
    localparam int NP = 6;
    localparam logic [7:0] PAT [NP] = '{8'h95, 8'h6A, 8'h01, 8'h80, 8'hFF, 8'h00};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] data;
    logic [2:0] op;
    logic [2:0] amt;
    logic [7:0] res;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    wsh_word_shifter dut (.data_i(data), .op_i(op), .amt_i(amt), .result_o(res));

    function automatic logic [7:0] model(input logic [2:0] o, input int n, input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < W; i++) begin
            case (o)
                3'b000: r[i] = (i >= n) ? d[i-n] : 1'b0;
                3'b001: r[i] = (i + n < W) ? d[i+n] : 1'b0;
                3'b010: r[i] = (i >= n) ? d[i-n] : d[0];
                3'b011: r[i] = (i + n < W) ? d[i+n] : d[W-1];
                3'b100: r[i] = d[(i - n + W) % W];
                3'b101: r[i] = d[(i + n) % W];
                default: r[i] = d[i];
            endcase
        end
        return r;
    endfunction

    function automatic string tag(input logic [2:0] o, input int n);
        if (n == 0) return "R8";
        case (o)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b100: return "R5";
            3'b101: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_run++;
        if (res !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b amt=%0d data=%h actual=%h expected=%h",
                     req, op, amt, data, res, exp);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        op = o; amt = a; data = d;
        #1;
    endtask

    initial begin
        data = '0; op = '0; amt = '0;
        @(negedge clk); #1;
        check("R8", 8'h00);   // quiet start: zero word, zero amount

        // Vector table: worked examples and edge fills
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][21:19], VEC[v][18:16], VEC[v][15:8]);
            check(tag(VEC[v][21:19], int'(VEC[v][18:16])), VEC[v][7:0]);
        end

        // Exhaustive sweep: every code, every amount, several patterns
        for (int o = 0; o < 8; o++)
            for (int a = 0; a < W; a++)
                for (int p = 0; p < NP; p++) begin
                    apply(3'(o), 3'(a), PAT[p]);
                    check(tag(3'(o), a), model(3'(o), a, PAT[p]));
                end

        // R9: change within one cycle shows without a clock edge
        apply(3'b100, 3'd1, 8'h81);
        check("R9", 8'h03);
        data = 8'h40; #1;
        check("R9", 8'h80);
        op = 3'b011; #1;
        check("R9", 8'h20);
        amt = 3'd0; #1;
        check("R9", 8'h40);

        // R7 with spare codes at maximum amount and unusual data
        apply(3'b111, 3'd7, 8'h01);
        check("R7", 8'h01);
        apply(3'b110, 3'd1, 8'h80);
        check("R7", 8'h80);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_fail++;
                n_run++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule